// File: doc/BRIEF.md
# Pointer Address Generation Unit

This block keeps the three 16-bit data pointers X, Y and Z, each stored as a low and a high 8-bit half. For every indirect load or store it computes the data-memory address and, where the addressing mode asks for it, the updated pointer value. The four modes are plain indirect, post-increment, pre-decrement and displacement. In post-increment the old pointer value is the address and the pointer then steps up by one. In pre-decrement the pointer steps down first and the new value is the address. Displacement adds an unsigned 6-bit offset without changing the pointer, and it is available on Y and Z only.

The surrounding core loads pointer halves through a byte-wide load port. It launches an operation with a one-cycle start strobe that carries the pointer select, the mode and the offset. Every operation takes two clock cycles. The unit holds busy for both cycles. In the second cycle it raises the memory strobe with the address and, for the stepping modes, presents the pointer write-back. The Z pointer is also brought out continuously so that program-memory reads and indirect jumps can use it as their address.

Top module: `ptr_agu`

## Requirements
- R1: After reset, busy, mem_stb and wb_en are low and all three pointers are 0, so z_ptr reads 0 and a plain access through X addresses 0.
- R2: When the unit is idle, a cycle with ld_en high writes ld_data into one half of the pointer named by ld_sel (0 = X, 1 = Y, 2 = Z). ld_hi = 0 selects bits 7:0 and ld_hi = 1 selects bits 15:8. z_ptr always shows the current Z value.
- R3: A start seen while the unit is idle begins an operation. busy is high in the two cycles after that clock edge. mem_stb is high in the second of those cycles only, and mem_addr is valid there. busy is low in the cycle after that.
- R4: Mode 0 (plain) addresses the selected pointer's value, gives no write-back and leaves the pointer unchanged.
- R5: Mode 1 (post-increment) addresses the old pointer value and writes back old + 1 modulo 2^16. The pointer holds the new value from the cycle after mem_stb.
- R6: Mode 2 (pre-decrement) addresses old − 1 modulo 2^16 and writes back that same value.
- R7: Mode 3 (displacement) on Y or Z addresses the pointer plus disp, taken as unsigned 0 to 63 and added modulo 2^16. It gives no write-back.
- R8: Mode 3 on X ignores disp and behaves as plain indirect.
- R9: A start or a load presented while busy is high has no effect.
- R10: A start with ptr_sel = 3 is ignored. busy stays low and no memory access occurs.
- R11: During a write-back, wb_sel names the pointer being updated, using the encoding of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load one pointer half this cycle |
| ld_sel | input | 2 | Pointer to load (0 X, 1 Y, 2 Z) |
| ld_hi | input | 1 | 1 selects the high half, 0 the low half |
| ld_data | input | 8 | Byte to load |
| start | input | 1 | Launch an indirect access |
| ptr_sel | input | 2 | Pointer used by the access (3 is ignored) |
| mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| disp | input | 6 | Unsigned displacement |
| busy | output | 1 | Operation in progress (both cycles) |
| mem_stb | output | 1 | Memory access strobe, second cycle |
| mem_addr | output | 16 | Effective address, valid with mem_stb |
| wb_en | output | 1 | Pointer write-back this cycle |
| wb_sel | output | 2 | Pointer being written back |
| wb_ptr | output | 16 | New pointer value |
| z_ptr | output | 16 | Current Z pointer |

## Verification
The hardest situations to reach from the ports are the wrap boundaries and requests that arrive in the middle of an operation. For the wrap boundaries, a pointer is loaded half by half to 0xFFFF or 0x0000 before a post-increment, pre-decrement or displacement crosses the 16-bit limit. For the mid-operation cases, the stimulus raises start with different arguments, or raises a load of Z, during the first busy cycle. A later plain access then reveals whether the pointer or the operation count was disturbed. A scoreboard checks the address and write-back of every strobe, and a strobe that arrives with nothing expected counts as a failure.

// File: rtl/ptr_agu_pkg.sv
// Shared types for the pointer address generation unit.
// Assumes exactly three pointers, selected by a 2-bit code.
package ptr_agu_pkg;
    localparam int NUM_PTR = 3;

    typedef enum logic [1:0] {
        SEL_X    = 2'd0,
        SEL_Y    = 2'd1,
        SEL_Z    = 2'd2,
        SEL_NONE = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        AM_PLAIN   = 2'd0,
        AM_POSTINC = 2'd1,
        AM_PREDEC  = 2'd2,
        AM_DISP    = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } agu_state_e;
endpackage

// File: rtl/ptr_agu_ctrl.sv
// Two-cycle sequencer. It accepts a start only when idle with a valid
// pointer select, captures the request and walks through the first and
// second cycles. It assumes start is a single-cycle strobe.
module ptr_agu_ctrl
    import ptr_agu_pkg::*;
#(
    parameter int DISP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        sel_i,
    input  logic [1:0]        mode_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic              busy,
    output logic              access,
    output ptr_sel_e          op_sel,
    output addr_mode_e        op_mode,
    output logic [DISP_W-1:0] op_disp
);
    agu_state_e state_q;
    logic       accept;

    // Decide whether a start begins an operation this cycle.
    always_comb begin
        accept = (state_q == ST_IDLE) && start && (sel_i != 2'd3);
    end

    // Advance the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:   if (accept) state_q <= ST_FIRST;
                ST_FIRST:  state_q <= ST_SECOND;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the request at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_sel  <= SEL_X;
            op_mode <= AM_PLAIN;
            op_disp <= '0;
        end else if (accept) begin
            op_sel  <= ptr_sel_e'(sel_i);
            op_mode <= addr_mode_e'(mode_i);
            op_disp <= disp_i;
        end
    end

    // Drive the status outputs from the state.
    always_comb begin
        busy   = (state_q != ST_IDLE);
        access = (state_q == ST_SECOND);
    end

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy); // R3
    AST_ACCESS_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        access |-> ($past(busy) && !$past(access))); // R3
    AST_BAD_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && sel_i == 2'd3) |=> !busy); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !access) |=> $stable(op_mode) && $stable(op_sel)); // R9
endmodule

// File: rtl/ptr_agu_regs.sv
// Pointer storage: each pointer is a pair of byte halves. The write-back
// of an operation replaces a whole pointer. A half load is taken only while
// the unit is idle, so no load can collide with a write-back.
module ptr_agu_regs
    import ptr_agu_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            busy,
    input  logic                            ld_en,
    input  logic [1:0]                      ld_sel,
    input  logic                            ld_hi,
    input  logic [PTR_W/2-1:0]              ld_data,
    input  logic                            wb_en,
    input  logic [1:0]                      wb_sel,
    input  logic [PTR_W-1:0]                wb_val,
    output logic [NUM_PTR-1:0][PTR_W-1:0]   ptrs
);
    localparam int HALF_W = PTR_W / 2;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        logic [HALF_W-1:0] lo_q;
        logic [HALF_W-1:0] hi_q;
        logic              wb_hit;
        logic              ld_hit;

        // Decode which update targets this pointer.
        always_comb begin
            wb_hit = wb_en && (wb_sel == 2'(g));
            ld_hit = ld_en && !busy && (ld_sel == 2'(g));
        end

        // Update the two halves of this pointer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (wb_hit) begin
                lo_q <= wb_val[HALF_W-1:0];
                hi_q <= wb_val[PTR_W-1:HALF_W];
            end else if (ld_hit) begin
                if (ld_hi) hi_q <= ld_data;
                else       lo_q <= ld_data;
            end
        end

        assign ptrs[g] = {hi_q, lo_q};
    end

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wb_en) |=> $stable(ptrs)); // R9
endmodule

// File: rtl/ptr_agu_calc.sv
// Address and write-back arithmetic. One adder adds +1, -1, the
// displacement or zero to the selected pointer. The effective address is
// either the unmodified pointer (post-increment) or the adder result.
// It assumes op_* stay stable through the operation.
module ptr_agu_calc
    import ptr_agu_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int DISP_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          access,
    input  logic [NUM_PTR-1:0][PTR_W-1:0] ptrs,
    input  ptr_sel_e                      op_sel,
    input  addr_mode_e                    op_mode,
    input  logic [DISP_W-1:0]             op_disp,
    output logic [PTR_W-1:0]              mem_addr,
    output logic                          wb_en,
    output logic [1:0]                    wb_sel,
    output logic [PTR_W-1:0]              wb_val
);
    logic [PTR_W-1:0] cur;
    logic [PTR_W-1:0] operand;
    logic [PTR_W-1:0] sum;
    logic             disp_ok;

    // Pick the pointer the operation works on.
    always_comb begin
        case (op_sel)
            SEL_X:   cur = ptrs[0];
            SEL_Y:   cur = ptrs[1];
            SEL_Z:   cur = ptrs[2];
            default: cur = '0;
        endcase
    end

    // Choose the adder operand from the mode; X takes no displacement.
    always_comb begin
        disp_ok = (op_sel != SEL_X);
        case (op_mode)
            AM_POSTINC: operand = PTR_W'(1);
            AM_PREDEC:  operand = '1;
            AM_DISP:    operand = disp_ok ? PTR_W'(op_disp) : '0;
            default:    operand = '0;
        endcase
    end

    // Form the address and the write-back.
    always_comb begin
        sum      = cur + operand;
        mem_addr = (op_mode == AM_POSTINC) ? cur : sum;
        wb_val   = sum;
        wb_sel   = op_sel;
        wb_en    = access && ((op_mode == AM_POSTINC) || (op_mode == AM_PREDEC));
    end

    AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (access && op_mode == AM_POSTINC) |-> (wb_en && wb_val == PTR_W'(mem_addr + 1'b1))); // R5
    AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (access && op_mode == AM_PREDEC) |-> (wb_en && wb_val == mem_addr)); // R6
    AST_NO_WB_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        (access && (op_mode == AM_PLAIN || op_mode == AM_DISP)) |-> !wb_en); // R4
    AST_DISP_X_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (access && op_mode == AM_DISP && op_sel == SEL_X) |-> (mem_addr == ptrs[0])); // R8
endmodule

// File: rtl/ptr_agu.sv
// Top of the pointer address generation unit: sequencer, pointer storage
// and address arithmetic. Outputs are valid as described per port; the
// memory strobe and write-back occur together in the second cycle.
module ptr_agu
    import ptr_agu_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int DISP_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [1:0]           ld_sel,
    input  logic                 ld_hi,
    input  logic [PTR_W/2-1:0]   ld_data,
    input  logic                 start,
    input  logic [1:0]           ptr_sel,
    input  logic [1:0]           mode,
    input  logic [DISP_W-1:0]    disp,
    output logic                 busy,
    output logic                 mem_stb,
    output logic [PTR_W-1:0]     mem_addr,
    output logic                 wb_en,
    output logic [1:0]           wb_sel,
    output logic [PTR_W-1:0]     wb_ptr,
    output logic [PTR_W-1:0]     z_ptr
);
    logic [NUM_PTR-1:0][PTR_W-1:0] ptrs;
    ptr_sel_e                      op_sel;
    addr_mode_e                    op_mode;
    logic [DISP_W-1:0]             op_disp;
    logic                          access;

    ptr_agu_ctrl #(.DISP_W(DISP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_i(ptr_sel),
        .mode_i(mode), .disp_i(disp), .busy(busy), .access(access),
        .op_sel(op_sel), .op_mode(op_mode), .op_disp(op_disp)
    );

    ptr_agu_regs #(.PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .busy(busy), .ld_en(ld_en),
        .ld_sel(ld_sel), .ld_hi(ld_hi), .ld_data(ld_data),
        .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_ptr), .ptrs(ptrs)
    );

    ptr_agu_calc #(.PTR_W(PTR_W), .DISP_W(DISP_W)) u_calc (
        .clk(clk), .rst_n(rst_n), .access(access), .ptrs(ptrs),
        .op_sel(op_sel), .op_mode(op_mode), .op_disp(op_disp),
        .mem_addr(mem_addr), .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_ptr)
    );

    // Bring out the strobe and the Z pointer.
    always_comb begin
        mem_stb = access;
        z_ptr   = ptrs[2];
    end

    AST_WB_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (mem_stb && busy)); // R3
    AST_Z_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_sel == 2'd2) |=> (z_ptr == $past(wb_ptr))); // R11
endmodule

// File: tb/ptr_agu_bench.sv
module ptr_agu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic        ld_hi = 1'b0;
    logic [7:0]  ld_data = '0;
    logic        start = 1'b0;
    logic [1:0]  ptr_sel = '0;
    logic [1:0]  mode = '0;
    logic [5:0]  disp = '0;
    logic        busy, mem_stb, wb_en;
    logic [15:0] mem_addr, wb_ptr, z_ptr;
    logic [1:0]  wb_sel;

    int checks = 0;
    int fails = 0;
    logic [15:0] model [3];

    typedef struct packed {
        logic [15:0] addr;
        logic        wen;
        logic [1:0]  wsel;
        logic [15:0] wval;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    ptr_agu u_ptr_agu (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_hi(ld_hi), .ld_data(ld_data), .start(start), .ptr_sel(ptr_sel),
        .mode(mode), .disp(disp), .busy(busy), .mem_stb(mem_stb),
        .mem_addr(mem_addr), .wb_en(wb_en), .wb_sel(wb_sel),
        .wb_ptr(wb_ptr), .z_ptr(z_ptr)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected item per memory strobe.
    always @(negedge clk) begin
        if (rst_n && mem_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R10 unexpected strobe", mem_addr, 16'h0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(mem_addr == e.addr, {t, " address"}, mem_addr, e.addr);
                check(wb_en == e.wen, {t, " write-back enable"}, 16'(wb_en), 16'(e.wen));
                if (e.wen) begin
                    check(wb_sel == e.wsel, "R11 wb_sel", 16'(wb_sel), 16'(e.wsel));
                    check(wb_ptr == e.wval, {t, " write-back value"}, wb_ptr, e.wval);
                end
            end
        end
    end

    task automatic load_half(input logic [1:0] s, input bit hi, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = s; ld_hi = hi; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        if (hi) model[s][15:8] = d;
        else    model[s][7:0]  = d;
    endtask

    task automatic load_ptr(input logic [1:0] s, input logic [15:0] v);
        load_half(s, 1'b0, v[7:0]);
        load_half(s, 1'b1, v[15:8]);
    endtask

    // Driver: launches one operation, optionally with a disturbing start or
    // load during the first busy cycle, and pushes the expected strobe.
    task automatic run_op(input logic [1:0] s, input logic [1:0] m, input logic [5:0] q,
                          input string tag, input bit poke_start, input bit poke_ld);
        exp_t e;
        logic [15:0] p;
        p = model[s];
        e.wen = 1'b0; e.wsel = s; e.wval = '0;
        case (m)
            2'd0: e.addr = p;
            2'd1: begin e.addr = p; e.wen = 1'b1; e.wval = p + 16'd1; end
            2'd2: begin e.addr = p - 16'd1; e.wen = 1'b1; e.wval = p - 16'd1; end
            default: e.addr = (s == 2'd0) ? p : p + 16'(q);
        endcase
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (e.wen) model[s] = e.wval;
        @(negedge clk);
        start = 1'b1; ptr_sel = s; mode = m; disp = q;
        @(negedge clk);
        start = poke_start;
        if (poke_start) begin ptr_sel = 2'd1; mode = 2'd1; disp = 6'd9; end
        if (poke_ld) begin ld_en = 1'b1; ld_sel = 2'd2; ld_hi = 1'b1; ld_data = 8'h5A; end
        check(busy === 1'b1, "R3 busy in first cycle", 16'(busy), 16'd1);
        check(mem_stb === 1'b0, "R3 no strobe in first cycle", 16'(mem_stb), 16'd0);
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        check(busy === 1'b1, "R3 busy in second cycle", 16'(busy), 16'd1);
        check(mem_stb === 1'b1, "R3 strobe in second cycle", 16'(mem_stb), 16'd1);
        @(negedge clk);
        check(busy === 1'b0, poke_start ? "R9 start while busy ignored" : "R3 busy ends",
              16'(busy), 16'd0);
        check(mem_stb === 1'b0, "R3 strobe one cycle", 16'(mem_stb), 16'd0);
    endtask

    task automatic op(input logic [1:0] s, input logic [1:0] m, input logic [5:0] q,
                      input string tag);
        run_op(s, m, q, tag, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        check(busy === 1'b0, "R1 busy after reset", 16'(busy), 16'd0);
        check(mem_stb === 1'b0, "R1 strobe after reset", 16'(mem_stb), 16'd0);
        check(wb_en === 1'b0, "R1 wb_en after reset", 16'(wb_en), 16'd0);
        check(z_ptr === 16'h0, "R1 z_ptr after reset", z_ptr, 16'h0);
        rst_n = 1'b1;
        op(2'd0, 2'd0, 6'd0, "R1 X at reset");

        // R2: half loads
        load_half(2'd2, 1'b0, 8'hFF);
        check(z_ptr === 16'h00FF, "R2 Z low half", z_ptr, 16'h00FF);
        load_half(2'd2, 1'b1, 8'hFF);
        check(z_ptr === 16'hFFFF, "R2 Z high half", z_ptr, 16'hFFFF);
        load_ptr(2'd0, 16'h1234);
        load_ptr(2'd1, 16'h1000);
        op(2'd0, 2'd0, 6'd0, "R2 X loaded");

        // R4: plain leaves pointer unchanged
        op(2'd0, 2'd0, 6'd0, "R4 plain X");
        op(2'd1, 2'd0, 6'd0, "R4 plain Y");

        // R5: post-increment, including wrap
        op(2'd0, 2'd1, 6'd0, "R5 postinc X");
        op(2'd0, 2'd1, 6'd0, "R5 postinc X again");
        op(2'd0, 2'd0, 6'd0, "R5 X after postinc");
        op(2'd2, 2'd1, 6'd0, "R5 postinc Z wrap");
        check(z_ptr === 16'h0000, "R5 Z wrapped to zero", z_ptr, 16'h0000);

        // R6: pre-decrement, including wrap
        op(2'd1, 2'd2, 6'd0, "R6 predec Y");
        op(2'd2, 2'd2, 6'd0, "R6 predec Z wrap");
        check(z_ptr === 16'hFFFF, "R6 Z wrapped to all ones", z_ptr, 16'hFFFF);
        op(2'd1, 2'd0, 6'd0, "R6 Y after predec");

        // R7: displacement on Y and Z
        op(2'd1, 2'd3, 6'd63, "R7 disp Y 63");
        op(2'd1, 2'd3, 6'd0, "R7 disp Y 0");
        op(2'd2, 2'd3, 6'd5, "R7 disp Z wrap");
        op(2'd1, 2'd0, 6'd0, "R7 Y unchanged");

        // R8: displacement on X is plain
        op(2'd0, 2'd3, 6'd20, "R8 disp X ignored");

        // R9: start and load during busy ignored
        run_op(2'd0, 2'd0, 6'd0, "R9 op with start poke", 1'b1, 1'b0);
        op(2'd1, 2'd0, 6'd0, "R9 Y not stepped");
        run_op(2'd0, 2'd0, 6'd0, "R9 op with load poke", 1'b0, 1'b1);
        check(z_ptr === 16'hFFFF, "R9 Z not loaded while busy", z_ptr, 16'hFFFF);
        op(2'd2, 2'd0, 6'd0, "R9 Z plain after poke");

        // R10: select code 3 ignored
        @(negedge clk);
        start = 1'b1; ptr_sel = 2'd3; mode = 2'd1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b0, "R10 no busy for select 3", 16'(busy), 16'd0);
        @(negedge clk);
        check(busy === 1'b0, "R10 still idle", 16'(busy), 16'd0);
        check(mem_stb === 1'b0, "R10 no strobe", 16'(mem_stb), 16'd0);
        @(negedge clk);
        check(exp_q.size() == 0, "R3 all strobes seen", 16'(exp_q.size()), 16'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule